// File: doc/BRIEF.md
# Predicated vector move and broadcast unit

This unit forms a new 512-bit vector destination value from one of several move forms selected by a 3-bit operation code. The forms are a straight copy of the source, a per-lane merge of source and old destination under an 8-bit-per-lane mask, a broadcast of an immediate into 8-bit or 16-bit lanes, an expansion of a 64-bit packed predicate into byte lanes, and a selection of the even or odd 16-bit lanes of the source.

A separate path copies a 1536-bit accumulator unchanged. Every result is registered one clock after a valid request, and both outputs hold their value while no request is present. The unit sits between register read and register write-back. It owns no storage beyond its output registers.

Top module: `vmov_unit`

## Requirements
- R1: During and right after reset, dstVec and wideDst are all zeros, and dstValid and wideValid are low.
- R2: opSel 0 (copy): one cycle after the request, dstVec equals srcVec in all 512 bits.
- R3: opSel 1 (merge): for each of the 64 byte lanes i, dstVec lane i becomes srcVec lane i when laneMask[8i+7:8i] is nonzero, and otherwise keeps oldVec lane i (never zero). Example: source 0xAA, old 0x55 and mask 0 give 0x55.
- R4: opSel 2 (byte broadcast): every byte lane of dstVec becomes immVal[7:0].
- R5: opSel 3 (halfword broadcast): every 16-bit lane of dstVec becomes immVal[15:0].
- R6: opSel 4 (predicate expand): byte lane i of dstVec is 0xFF when predBits[i] is 1 and 0x00 when it is 0.
- R7: opSel 6 selects the even 16-bit source lanes and opSel 7 selects the odd ones. Only bit 0 of the code tells the two apart. Result lane k (k = 0..15) is source lane 2k or 2k+1, and dstVec[511:256] is zero.
- R8: opSel 5 (wide copy): one cycle later wideDst equals wideSrc in all 1536 bits and wideValid is high. dstVec is unchanged and dstValid is low.
- R9: dstValid is high in exactly the cycle after each request whose opSel is not 5, and wideValid is low in that cycle.
- R10: In the cycle after a cycle with reqValid low, dstVec and wideDst are unchanged, and dstValid and wideValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| opSel | input | 3 | Move form code |
| srcVec | input | 512 | Source vector |
| oldVec | input | 512 | Previous destination vector, used by the merge |
| laneMask | input | 512 | Per-byte-lane mask; a nonzero byte means write |
| predBits | input | 64 | Packed predicate, one bit per byte lane |
| immVal | input | 16 | Immediate for the broadcasts |
| wideSrc | input | 1536 | Accumulator source for the wide copy |
| dstVec | output | 512 | Registered vector result |
| dstValid | output | 1 | Vector result updated last cycle |
| wideDst | output | 1536 | Registered accumulator copy |
| wideValid | output | 1 | Accumulator copy updated last cycle |

## Verification
The properties assume that the input values are held for the whole cycle in which reqValid is high. They compare each result with the inputs sampled on that edge, so the stimulus changes inputs only on the falling clock edge. All eight opSel codes are defined, so any code is legal stimulus. The bench uses mask bytes that are zero as well as small, odd and high-bit-only nonzero values, which exercises the any-nonzero rule without leaving the defined input space.

// File: rtl/vmov_pkg.sv
package vmov_pkg;
  parameter int VEC_W    = 512;
  parameter int MERGE_LW = 8;
  parameter int HALF_LW  = 16;
  parameter int WIDE_W   = 1536;
  parameter int IMM_W    = 16;
  parameter int OP_W     = 3;

  localparam int MERGE_LANES = VEC_W / MERGE_LW;
  localparam int HALF_LANES  = VEC_W / HALF_LW;
  localparam int PICK_LANES  = HALF_LANES / 2;

  typedef enum logic [OP_W-1:0] {
    OP_COPY      = 3'd0,
    OP_MERGE     = 3'd1,
    OP_BCAST8    = 3'd2,
    OP_BCAST16   = 3'd3,
    OP_PEXPAND   = 3'd4,
    OP_WIDE      = 3'd5,
    OP_HALF_EVEN = 3'd6,
    OP_HALF_ODD  = 3'd7
  } vmovOp_e;

  typedef enum logic [2:0] {
    F_COPY, F_MERGE, F_B8, F_B16, F_PEXP, F_HALF
  } vecForm_e;

  typedef struct packed {
    logic     loadVec;
    logic     loadWide;
    vecForm_e form;
    logic     halfOdd;
  } strobes_t;
endpackage

// File: rtl/vmov_ctrl.sv
module vmov_ctrl
  import vmov_pkg::*;
(
  input  logic            reqValid,
  input  logic [OP_W-1:0] opSel,
  output strobes_t        st
);
  vmovOp_e op;
  assign op = vmovOp_e'(opSel);

  always_comb begin
    st = '0;
    st.form = F_COPY;
    if (reqValid) begin
      st.loadVec = 1'b1;
      unique case (op)
        OP_COPY:    st.form = F_COPY;
        OP_MERGE:   st.form = F_MERGE;
        OP_BCAST8:  st.form = F_B8;
        OP_BCAST16: st.form = F_B16;
        OP_PEXPAND: st.form = F_PEXP;
        OP_WIDE: begin
          st.loadVec  = 1'b0;
          st.loadWide = 1'b1;
        end
        OP_HALF_EVEN, OP_HALF_ODD: begin
          st.form    = F_HALF;
          st.halfOdd = opSel[0];
        end
        default: st.form = F_COPY;
      endcase
    end
  end
endmodule

// File: rtl/vmov_datapath.sv
module vmov_datapath
  import vmov_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobes_t               st,
  input  logic [VEC_W-1:0]       srcVec,
  input  logic [VEC_W-1:0]       oldVec,
  input  logic [VEC_W-1:0]       laneMask,
  input  logic [MERGE_LANES-1:0] predBits,
  input  logic [IMM_W-1:0]       immVal,
  input  logic [WIDE_W-1:0]      wideSrc,
  output logic [VEC_W-1:0]       dstVec,
  output logic                   dstValid,
  output logic [WIDE_W-1:0]      wideDst,
  output logic                   wideValid
);
  logic [VEC_W-1:0] mergeV, b8V, b16V, pexpV, halfV, nextVec;

  for (genvar g = 0; g < MERGE_LANES; g++) begin : gByte
    assign mergeV[g*MERGE_LW +: MERGE_LW] = (|laneMask[g*MERGE_LW +: MERGE_LW])
                                            ? srcVec[g*MERGE_LW +: MERGE_LW]
                                            : oldVec[g*MERGE_LW +: MERGE_LW];
    assign pexpV[g*MERGE_LW +: MERGE_LW]  = {MERGE_LW{predBits[g]}};
    assign b8V[g*MERGE_LW +: MERGE_LW]    = immVal[MERGE_LW-1:0];
  end

  for (genvar h = 0; h < HALF_LANES; h++) begin : gHalf
    assign b16V[h*HALF_LW +: HALF_LW] = immVal[HALF_LW-1:0];
  end

  for (genvar k = 0; k < PICK_LANES; k++) begin : gPick
    assign halfV[k*HALF_LW +: HALF_LW] = st.halfOdd
                                         ? srcVec[(2*k+1)*HALF_LW +: HALF_LW]
                                         : srcVec[(2*k)*HALF_LW +: HALF_LW];
  end
  assign halfV[VEC_W-1:VEC_W/2] = '0;

  always_comb begin
    unique case (st.form)
      F_MERGE: nextVec = mergeV;
      F_B8:    nextVec = b8V;
      F_B16:   nextVec = b16V;
      F_PEXP:  nextVec = pexpV;
      F_HALF:  nextVec = halfV;
      default: nextVec = srcVec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstVec    <= '0;
      dstValid  <= 1'b0;
      wideDst   <= '0;
      wideValid <= 1'b0;
    end else begin
      if (st.loadVec)  dstVec  <= nextVec;
      if (st.loadWide) wideDst <= wideSrc;
      dstValid  <= st.loadVec;
      wideValid <= st.loadWide;
    end
  end
endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
  import vmov_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [OP_W-1:0]        opSel,
  input  logic [VEC_W-1:0]       srcVec,
  input  logic [VEC_W-1:0]       oldVec,
  input  logic [VEC_W-1:0]       laneMask,
  input  logic [MERGE_LANES-1:0] predBits,
  input  logic [IMM_W-1:0]       immVal,
  input  logic [WIDE_W-1:0]      wideSrc,
  output logic [VEC_W-1:0]       dstVec,
  output logic                   dstValid,
  output logic [WIDE_W-1:0]      wideDst,
  output logic                   wideValid
);
  strobes_t st;

  vmov_ctrl uCtrl (
    .reqValid(reqValid),
    .opSel   (opSel),
    .st      (st)
  );

  vmov_datapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .srcVec   (srcVec),
    .oldVec   (oldVec),
    .laneMask (laneMask),
    .predBits (predBits),
    .immVal   (immVal),
    .wideSrc  (wideSrc),
    .dstVec   (dstVec),
    .dstValid (dstValid),
    .wideDst  (wideDst),
    .wideValid(wideValid)
  );
endmodule

// File: rtl/vmov_checker.sv
module vmov_checker
  import vmov_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic [OP_W-1:0]        opSel,
  input logic [VEC_W-1:0]       srcVec,
  input logic [VEC_W-1:0]       oldVec,
  input logic [VEC_W-1:0]       laneMask,
  input logic [MERGE_LANES-1:0] predBits,
  input logic [IMM_W-1:0]       immVal,
  input logic [WIDE_W-1:0]      wideSrc,
  input logic [VEC_W-1:0]       dstVec,
  input logic                   dstValid,
  input logic [WIDE_W-1:0]      wideDst,
  input logic                   wideValid
);
  assert_copy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == OP_COPY) |=> dstVec == $past(srcVec));

  for (genvar g = 0; g < MERGE_LANES; g++) begin : gLane
    assert_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && opSel == OP_MERGE) |=>
        dstVec[g*MERGE_LW +: MERGE_LW] ==
          (($past(laneMask[g*MERGE_LW +: MERGE_LW]) != '0)
            ? $past(srcVec[g*MERGE_LW +: MERGE_LW])
            : $past(oldVec[g*MERGE_LW +: MERGE_LW])));
    assert_bcast8_R4: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && opSel == OP_BCAST8) |=>
        dstVec[g*MERGE_LW +: MERGE_LW] == $past(immVal[MERGE_LW-1:0]));
    assert_pexp_R6: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && opSel == OP_PEXPAND) |=>
        dstVec[g*MERGE_LW +: MERGE_LW] == ($past(predBits[g]) ? {MERGE_LW{1'b1}} : '0));
  end

  assert_half_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (opSel == OP_HALF_EVEN || opSel == OP_HALF_ODD)) |=>
      dstVec[VEC_W-1:VEC_W/2] == '0);

  assert_wide_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == OP_WIDE) |=>
      (wideDst == $past(wideSrc)) && $stable(dstVec) && wideValid && !dstValid);

  assert_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel != OP_WIDE) |=> dstValid && !wideValid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(dstVec) && $stable(wideDst) && !dstValid && !wideValid);
endmodule

bind vmov_unit vmov_checker uChk (.*);

// File: tb/sim_vmov_unit.sv
module sim_vmov_unit;
  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    opSel = '0;
  logic [511:0]  srcVec = '0, oldVec = '0, laneMask = '0;
  logic [63:0]   predBits = '0;
  logic [15:0]   immVal = '0;
  logic [1535:0] wideSrc = '0;
  logic [511:0]  dstVec;
  logic          dstValid;
  logic [1535:0] wideDst;
  logic          wideValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vmov_unit u0 (.*);

  // entry: {op, seed, imm, pred}
  localparam logic [90:0] TBL [0:11] = '{
    {3'd0, 8'h11, 16'h0000, 64'h0},
    {3'd1, 8'h23, 16'h0000, 64'h0},
    {3'd2, 8'h00, 16'hBE5A, 64'h0},
    {3'd3, 8'h00, 16'h8001, 64'h0},
    {3'd4, 8'h00, 16'h0000, 64'h8000_0001_F0F0_0F0F},
    {3'd6, 8'h47, 16'h0000, 64'h0},
    {3'd7, 8'h47, 16'h0000, 64'h0},
    {3'd1, 8'h5C, 16'h0000, 64'h0},
    {3'd4, 8'h00, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {3'd4, 8'h00, 16'h0000, 64'h0},
    {3'd0, 8'hE9, 16'h0000, 64'h0},
    {3'd2, 8'h00, 16'h0080, 64'h0}
  };

  function automatic logic [511:0] mkVec(input logic [7:0] seed, input int salt);
    logic [511:0] v;
    for (int b = 0; b < 64; b++)
      v[b*8 +: 8] = 8'(int'(seed) * 37 + b * 13 + salt * 91) ^ 8'(b << 3);
    return v;
  endfunction

  function automatic logic [511:0] mkMask(input logic [7:0] seed);
    logic [511:0] v;
    for (int b = 0; b < 64; b++) begin
      if ((b + int'(seed)) % 3 == 0) v[b*8 +: 8] = 8'h00;
      else if ((b % 4) == 1)          v[b*8 +: 8] = 8'h80;
      else                            v[b*8 +: 8] = 8'((b * 5 + int'(seed)) % 255 + 1);
    end
    return v;
  endfunction

  function automatic logic [511:0] model(input logic [2:0] op, input logic [511:0] s,
      input logic [511:0] o, input logic [511:0] m, input logic [15:0] imm,
      input logic [63:0] p, input logic [511:0] prev);
    logic [511:0] r;
    r = '0;
    case (op)
      3'd0: r = s;
      3'd1: for (int b = 0; b < 64; b++) r[b*8 +: 8] = (m[b*8 +: 8] == 8'h0) ? o[b*8 +: 8] : s[b*8 +: 8];
      3'd2: for (int b = 0; b < 64; b++) r[b*8 +: 8] = imm[7:0];
      3'd3: for (int h = 0; h < 32; h++) r[h*16 +: 16] = imm;
      3'd4: for (int b = 0; b < 64; b++) r[b*8 +: 8] = p[b] ? 8'hFF : 8'h00;
      3'd5: r = prev;
      default: for (int k = 0; k < 16; k++) r[k*16 +: 16] = s[(2*k + int'(op[0]))*16 +: 16];
    endcase
    return r;
  endfunction

  task automatic checkVec(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkWide(input string req, input logic [1535:0] act, input logic [1535:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    opSel = op;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  logic [511:0] expVec;
  logic [1535:0] wideExp;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checkVec("R1 dstVec reset", dstVec, '0);
    checkWide("R1 wideDst reset", wideDst, '0);
    checkBit("R1 dstValid reset", dstValid, 1'b0);
    checkBit("R1 wideValid reset", wideValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1 dstVec after reset", dstVec, '0);
    expVec = '0;

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [2:0] op;
      logic [7:0] seed;
      op = TBL[i][90:88];
      seed = TBL[i][87:80];
      srcVec = mkVec(seed, 0);
      oldVec = mkVec(seed, 1);
      laneMask = mkMask(seed);
      immVal = TBL[i][79:64];
      predBits = TBL[i][63:0];
      expVec = model(op, srcVec, oldVec, laneMask, immVal, predBits, expVec);
      issue(op);
      case (op)
        3'd0: checkVec("R2 copy", dstVec, expVec);
        3'd1: checkVec("R3 merge", dstVec, expVec);
        3'd2: checkVec("R4 byte broadcast", dstVec, expVec);
        3'd3: checkVec("R5 halfword broadcast", dstVec, expVec);
        3'd4: checkVec("R6 predicate expand", dstVec, expVec);
        default: checkVec("R7 half select", dstVec, expVec);
      endcase
      checkBit("R9 dstValid after request", dstValid, 1'b1);
      checkBit("R9 wideValid low after vector request", wideValid, 1'b0);
    end

    // R10 hold with inputs changing but no request
    srcVec = ~srcVec;
    immVal = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    checkVec("R10 dstVec held", dstVec, expVec);
    checkBit("R10 dstValid low", dstValid, 1'b0);
    checkWide("R10 wideDst held", wideDst, '0);

    // R8 wide copy
    wideExp = {mkVec(8'h71, 2), mkVec(8'h72, 3), mkVec(8'h73, 4)};
    wideSrc = wideExp;
    srcVec = mkVec(8'h99, 5);
    issue(3'd5);
    checkWide("R8 wide copy", wideDst, wideExp);
    checkBit("R8 wideValid", wideValid, 1'b1);
    checkBit("R8 dstValid low", dstValid, 1'b0);
    checkVec("R8 dstVec unchanged", dstVec, expVec);
    wideSrc = '0;
    @(negedge clk);
    checkWide("R10 wideDst held after wide copy", wideDst, wideExp);
    checkBit("R10 wideValid low", wideValid, 1'b0);

    // R3 directed: 0xAA over 0x55 with several mask values
    for (int b = 0; b < 64; b++) begin
      srcVec[b*8 +: 8] = 8'hAA;
      oldVec[b*8 +: 8] = 8'h55;
    end
    laneMask = '0;
    laneMask[15:8] = 8'h01;
    laneMask[23:16] = 8'h07;
    laneMask[31:24] = 8'h80;
    issue(3'd1);
    checkVec("R3 mask zero keeps old", {448'h0, dstVec[63:56], dstVec[7:0]}, {448'h0, 8'h55, 8'h55});
    checkVec("R3 nonzero masks write", {488'h0, dstVec[31:8]}, {488'h0, 24'hAAAAAA});

    // R7 directed: lane index pattern, even then odd
    for (int h = 0; h < 32; h++) srcVec[h*16 +: 16] = 16'(16'hC000 + h);
    issue(3'd6);
    expVec = '0;
    for (int k = 0; k < 16; k++) expVec[k*16 +: 16] = 16'(16'hC000 + 2*k);
    checkVec("R7 even lanes", dstVec, expVec);
    issue(3'd7);
    for (int k = 0; k < 16; k++) expVec[k*16 +: 16] = 16'(16'hC000 + 2*k + 1);
    checkVec("R7 odd lanes", dstVec, expVec);

    // R1 reset again clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkVec("R1 dstVec re-reset", dstVec, '0);
    checkWide("R1 wideDst re-reset", wideDst, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule